// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block walks a processor core through the entry into an interrupt or exception handler. A `start` pulse hands it the vector number, whether the event is an exception, and an optional error code. The block then drives a single request/acknowledge port. Over that port it asks the surrounding core to look up the vector, to switch to a more privileged stack, to push words onto the stack, to clear the interrupt-enable flag, to load the new code segment and to set the new instruction pointer. The surrounding core does the work for each request and pulses `ack`. If the step failed, it raises `flt` in the same cycle.

The block keeps a nested-fault counter. A step that reports a fault abandons the current entry and at once starts a new one for the reported fault. From the second nested level on, the vector becomes double fault. At the third level the block gives up and requests a core reset. A successful entry ends with a one-cycle `done` pulse and clears the counter.

Top module: `intr_entry_seq`

## Requirements
- R1: Reset result: after reset `req_valid`, `done` and `rst_req` are low and the block is idle.
- R2: An accepted `start` first issues a vector lookup (`req_op`=0) with the vector number in `req_data[7:0]`. On its `ack` the block captures `tgt_sel`, `tgt_off` and `tgt_intgate`.
- R3: When `pe` is high and `cpl` is numerically greater than `tgt_sel[1:0]`, a stack switch request (`req_op`=1, `req_data` = that target level) follows the lookup. After it come pushes of the old `ss_sel` and then the old `esp`, both captured at the lookup acknowledge. With `pe` low no switch is ever requested.
- R4: Next come pushes (`req_op`=2) of `eflags`, `cs_sel` and the instruction pointer, in that order. The pointer is `saved_eip` for an exception and `eip` for an external interrupt.
- R5: Pushes made before the code-segment load carry `req_w16`=1 exactly when `pe` is low or `cs32` is low. In real mode every such push is therefore 16-bit.
- R6: When the captured gate flag marks an interrupt gate, a clear-interrupt-enable request (`req_op`=3) follows the instruction-pointer push. For a trap gate it is absent.
- R7: A code-segment load (`req_op`=4, `req_data` = selector) follows, then a set-pointer request (`req_op`=5). If `new_cs32` was high at the load acknowledge, the set-pointer request carries the full offset with `req_w16`=0. Otherwise it carries only the low 16 bits, zero-extended, with `req_w16`=1.
- R8: When the event carries an error code and `pe` is high, one last push of the error code follows the set-pointer request, sized by the new segment as in R7. Otherwise there is no such push.
- R9: Each exception, and each fault reported with an `ack`, adds one to the fault counter. A fault restarts the entry as an exception with error code `flt_code`. Its vector is 8 (double fault) once the counter exceeds one, and `flt_vec` otherwise. When the counter reaches three, `rst_req` pulses one cycle after the acknowledge and the block goes idle with the counter cleared.
- R10: The final acknowledge of a fault-free entry raises `done` for one cycle and clears the fault counter.
- R11: While `req_valid` is high and `ack` is low, `req_op`, `req_data` and `req_w16` stay unchanged.
- R12: `ack` and `flt` received while idle change nothing: no request, no pulse, and no counter change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an entry (accepted when idle) |
| is_exc | input | 1 | Event is an exception |
| exc_vec | input | 8 | Vector number of the event |
| has_err | input | 1 | Event carries an error code |
| err_code | input | 32 | Error code value |
| pe | input | 1 | Protected mode enabled |
| cpl | input | 2 | Current privilege level |
| cs32 | input | 1 | Current code segment is 32-bit |
| eflags | input | 32 | Current flags word |
| cs_sel | input | 16 | Current code selector |
| eip | input | 32 | Current instruction pointer |
| saved_eip | input | 32 | Pointer of the faulting instruction |
| ss_sel | input | 16 | Current stack selector |
| esp | input | 32 | Current stack pointer |
| req_valid | output | 1 | Request pending |
| req_op | output | 3 | Request kind (0 lookup, 1 switch, 2 push, 3 clear IF, 4 load CS, 5 set pointer) |
| req_data | output | 32 | Request operand |
| req_w16 | output | 1 | Operand is 16-bit |
| ack | input | 1 | Request completed this cycle |
| flt | input | 1 | Acknowledged request faulted |
| flt_vec | input | 8 | Vector of the reported fault |
| flt_code | input | 32 | Error code of the reported fault |
| tgt_sel | input | 16 | Handler selector, valid with lookup ack |
| tgt_off | input | 32 | Handler offset, valid with lookup ack |
| tgt_intgate | input | 1 | Handler is an interrupt gate, valid with lookup ack |
| new_cs32 | input | 1 | Loaded code segment is 32-bit, valid with load ack |
| done | output | 1 | Entry completed |
| rst_req | output | 1 | Triple fault, core reset requested |

## Verification
The bench builds the block with its defaults: 32-bit data, 8-bit vectors, double-fault vector 8 and a limit of three nested faults. Under that limit, two faults injected into an exception, or three into an external interrupt, reach the reset request. A single fault reaches the double-fault path for an exception and the plain fault path for an interrupt. Fault positions, privilege levels, gate kinds and segment sizes are drawn at random per entry, so stack switches, 16-bit forcing and error-code suppression all meet restarts at every step position.

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int W         = 32,
  parameter int SW        = 16,
  parameter int VW        = 8,
  parameter int DF_VEC    = 8,
  parameter int FAULT_MAX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_exc,
  input  logic [VW-1:0] exc_vec,
  input  logic          has_err,
  input  logic [W-1:0]  err_code,
  input  logic          pe,
  input  logic [1:0]    cpl,
  input  logic          cs32,
  input  logic [W-1:0]  eflags,
  input  logic [SW-1:0] cs_sel,
  input  logic [W-1:0]  eip,
  input  logic [W-1:0]  saved_eip,
  input  logic [SW-1:0] ss_sel,
  input  logic [W-1:0]  esp,
  output logic          req_valid,
  output logic [2:0]    req_op,
  output logic [W-1:0]  req_data,
  output logic          req_w16,
  input  logic          ack,
  input  logic          flt,
  input  logic [VW-1:0] flt_vec,
  input  logic [W-1:0]  flt_code,
  input  logic [SW-1:0] tgt_sel,
  input  logic [W-1:0]  tgt_off,
  input  logic          tgt_intgate,
  input  logic          new_cs32,
  output logic          done,
  output logic          rst_req
);
  localparam int CW = $clog2(FAULT_MAX + 1);
  localparam logic [CW:0]   LIM = (CW+1)'(FAULT_MAX);
  localparam logic [CW:0]   ONE = (CW+1)'(1);
  localparam logic [VW-1:0] DFV = VW'(DF_VEC);
  localparam logic [2:0] OP_LOOK = 3'd0, OP_SWCH = 3'd1, OP_PUSH = 3'd2,
                         OP_CLIF = 3'd3, OP_LDCS = 3'd4, OP_SETP = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_SWCH, S_PSS, S_PSP, S_PFL, S_PCS, S_PIP,
    S_CLIF, S_LDCS, S_SETP, S_PERR
  } st_t;

  st_t           st;
  logic [VW-1:0] vec_r;
  logic          exc_r, herr_r, gate_r, pw16_r, nw16_r;
  logic [W-1:0]  ecode_r, off_r, oesp_r;
  logic [SW-1:0] sel_r, oss_r;
  logic [CW-1:0] cnt;

  wire [CW:0] cnt_start = {1'b0, cnt} + {{CW{1'b0}}, is_exc};
  wire [CW:0] cnt_inc   = {1'b0, cnt} + ONE;
  wire        need_sw   = pe && (cpl > tgt_sel[1:0]);

  assign req_valid = (st != S_IDLE);

  always_comb begin
    req_op   = OP_PUSH;
    req_data = '0;
    req_w16  = 1'b0;
    case (st)
      S_LOOK: begin req_op = OP_LOOK; req_data = W'(vec_r); end
      S_SWCH: begin req_op = OP_SWCH; req_data = W'(sel_r[1:0]); end
      S_PSS:  begin req_data = W'(oss_r);  req_w16 = pw16_r; end
      S_PSP:  begin req_data = oesp_r;     req_w16 = pw16_r; end
      S_PFL:  begin req_data = eflags;     req_w16 = pw16_r; end
      S_PCS:  begin req_data = W'(cs_sel); req_w16 = pw16_r; end
      S_PIP:  begin req_data = exc_r ? saved_eip : eip; req_w16 = pw16_r; end
      S_CLIF: req_op = OP_CLIF;
      S_LDCS: begin req_op = OP_LDCS; req_data = W'(sel_r); end
      S_SETP: begin
        req_op   = OP_SETP;
        req_data = nw16_r ? W'(off_r[15:0]) : off_r;
        req_w16  = nw16_r;
      end
      S_PERR: begin req_data = ecode_r; req_w16 = nw16_r; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  done <= 1'b0;  rst_req <= 1'b0;
      vec_r <= '0;   exc_r <= 1'b0; herr_r <= 1'b0; gate_r <= 1'b0;
      pw16_r <= 1'b0; nw16_r <= 1'b0; ecode_r <= '0; off_r <= '0;
      oesp_r <= '0;  sel_r <= '0;  oss_r <= '0;
    end else begin
      done    <= 1'b0;
      rst_req <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          if (cnt_start >= LIM) begin
            rst_req <= 1'b1;
            cnt     <= '0;
          end else begin
            cnt     <= cnt_start[CW-1:0];
            vec_r   <= (cnt_start > ONE) ? DFV : exc_vec;
            exc_r   <= is_exc;
            herr_r  <= has_err;
            ecode_r <= err_code;
            st      <= S_LOOK;
          end
        end
      end else if (ack) begin
        if (flt) begin
          if (cnt_inc >= LIM) begin
            rst_req <= 1'b1;
            cnt     <= '0;
            st      <= S_IDLE;
          end else begin
            cnt     <= cnt_inc[CW-1:0];
            vec_r   <= (cnt_inc > ONE) ? DFV : flt_vec;
            exc_r   <= 1'b1;
            herr_r  <= 1'b1;
            ecode_r <= flt_code;
            st      <= S_LOOK;
          end
        end else begin
          case (st)
            S_LOOK: begin
              sel_r  <= tgt_sel;
              off_r  <= tgt_off;
              gate_r <= tgt_intgate;
              pw16_r <= !pe || !cs32;
              oss_r  <= ss_sel;
              oesp_r <= esp;
              st     <= need_sw ? S_SWCH : S_PFL;
            end
            S_SWCH: st <= S_PSS;
            S_PSS:  st <= S_PSP;
            S_PSP:  st <= S_PFL;
            S_PFL:  st <= S_PCS;
            S_PCS:  st <= S_PIP;
            S_PIP:  st <= gate_r ? S_CLIF : S_LDCS;
            S_CLIF: st <= S_LDCS;
            S_LDCS: begin nw16_r <= !new_cs32; st <= S_SETP; end
            S_SETP: begin
              if (herr_r && pe) st <= S_PERR;
              else begin st <= S_IDLE; done <= 1'b1; cnt <= '0; end
            end
            default: begin st <= S_IDLE; done <= 1'b1; cnt <= '0; end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         pe,
  input logic         req_valid,
  input logic [2:0]   req_op,
  input logic [W-1:0] req_data,
  input logic         req_w16,
  input logic         ack,
  input logic         flt,
  input logic         done,
  input logic         rst_req
);
  a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ack) |=> (req_valid && $stable(req_op) && $stable(req_data) && $stable(req_w16)));

  a_r3_switch_only_pm: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1) |-> pe);

  a_r9_reset_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(req_valid && ack && flt));

  a_r10_done_after_clean_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && ack && !flt));

  a_r9_done_reset_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && rst_req));

  a_r12_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !start) |=> (!req_valid && !done && !rst_req));
endmodule

bind intr_entry_seq intr_entry_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pe(pe),
  .req_valid(req_valid), .req_op(req_op), .req_data(req_data), .req_w16(req_w16),
  .ack(ack), .flt(flt), .done(done), .rst_req(rst_req)
);

// File: tb/tb_intr_entry_seq.sv
module tb_intr_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, is_exc = 0, has_err = 0, pe = 0, cs32 = 0;
  logic [7:0]  exc_vec = 0, flt_vec = 0;
  logic [31:0] err_code = 0, eflags = 0, eip = 0, saved_eip = 0, esp = 0, flt_code = 0, tgt_off = 0;
  logic [1:0]  cpl = 0;
  logic [15:0] cs_sel = 0, ss_sel = 0, tgt_sel = 0;
  logic ack = 0, flt = 0, tgt_intgate = 0, new_cs32 = 0;
  logic req_valid, req_w16, done, rst_req;
  logic [2:0]  req_op;
  logic [31:0] req_data;

  logic [15:0] pri_sel, df_sel;
  logic [31:0] pri_off, df_off;
  logic pri_gate, df_gate, pri_ncs, df_ncs;

  intr_entry_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int e_n;
  logic [2:0]  e_op[16];
  logic [31:0] e_dat[16];
  logic        e_w[16];
  string       e_tag[16];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic add(input logic [2:0] op, input logic [31:0] d, input logic w, input string tag);
    e_op[e_n] = op; e_dat[e_n] = d; e_w[e_n] = w; e_tag[e_n] = tag; e_n++;
  endtask

  task automatic build(input logic [7:0] v, input bit ex, input bit he, input logic [31:0] ec);
    logic [15:0] sel; logic [31:0] off; logic g, nc, pw;
    sel = (v == 8) ? df_sel : pri_sel;
    off = (v == 8) ? df_off : pri_off;
    g   = (v == 8) ? df_gate : pri_gate;
    nc  = (v == 8) ? df_ncs : pri_ncs;
    tgt_sel = sel; tgt_off = off; tgt_intgate = g; new_cs32 = nc;
    pw = !pe || !cs32;
    e_n = 0;
    add(3'd0, {24'b0, v}, 1'b0, "R2 R9 lookup");
    if (pe && cpl > sel[1:0]) begin
      add(3'd1, {30'b0, sel[1:0]}, 1'b0, "R3 switch");
      add(3'd2, {16'b0, ss_sel}, pw, "R3 old SS");
      add(3'd2, esp, pw, "R3 old ESP");
    end
    add(3'd2, eflags, pw, "R4 R5 flags");
    add(3'd2, {16'b0, cs_sel}, pw, "R4 R5 CS");
    add(3'd2, ex ? saved_eip : eip, pw, "R4 R5 IP");
    if (g) add(3'd3, 32'd0, 1'b0, "R6 clear IF");
    add(3'd4, {16'b0, sel}, 1'b0, "R7 load CS");
    add(3'd5, nc ? off : {16'b0, off[15:0]}, !nc, "R7 set pointer");
    if (he && pe) add(3'd2, ec, !nc, "R8 error code");
  endtask

  task automatic deliver(input bit ex, input logic [7:0] v0, input bit he, input logic [31:0] ec,
                         input int f0, input int f1, input int f2);
    int cnt, r, k, fp[3];
    bit fault;
    fp[0] = f0; fp[1] = f1; fp[2] = f2;
    is_exc = ex; exc_vec = v0; has_err = he; err_code = ec;
    start = 1;
    @(negedge clk);
    start = 0;
    cnt = ex ? 1 : 0;
    build((cnt > 1) ? 8'd8 : v0, ex, he, ec);
    r = 0; k = 0;
    while (1) begin
      chk(req_valid && req_op == e_op[k] && req_data == e_data_at(k) && req_w16 == e_w[k],
          e_tag[k], "request", {req_valid, req_op, req_data},
          {1'b1, e_op[k], e_dat[k]});
      if (req_w16 !== e_w[k]) chk(0, e_tag[k], "width", {35'b0, req_w16}, {35'b0, e_w[k]});
      repeat ($urandom % 3) @(negedge clk);
      fault = (r < 3) && (k == fp[r]);
      ack = 1; flt = fault;
      @(negedge clk);
      ack = 0; flt = 0;
      if (fault) begin
        cnt++; r++;
        if (cnt >= 3) begin
          chk(rst_req && !req_valid && !done, "R9", "triple fault reset",
              {33'b0, rst_req, req_valid, done}, {33'b0, 3'b100});
          @(negedge clk);
          chk(!rst_req && !req_valid, "R9", "reset pulse one cycle",
              {34'b0, rst_req, req_valid}, 36'd0);
          return;
        end
        build((cnt > 1) ? 8'd8 : flt_vec, 1'b1, 1'b1, flt_code);
        k = 0;
      end else begin
        k++;
        if (k == e_n) begin
          chk(done && !req_valid && !rst_req, "R10", "done after last ack",
              {33'b0, done, req_valid, rst_req}, {33'b0, 3'b100});
          @(negedge clk);
          chk(!done && !req_valid, "R10", "done one cycle",
              {34'b0, done, req_valid}, 36'd0);
          return;
        end
      end
    end
  endtask

  function automatic logic [31:0] e_data_at(input int k);
    return e_dat[k];
  endfunction

  task automatic rand_env();
    pe = $urandom % 2; cpl = 2'($urandom); cs32 = $urandom % 2;
    eflags = $urandom; cs_sel = 16'($urandom); eip = $urandom; saved_eip = $urandom;
    ss_sel = 16'($urandom); esp = $urandom;
    pri_sel = 16'($urandom); pri_off = $urandom; pri_gate = $urandom % 2; pri_ncs = $urandom % 2;
    df_sel = 16'($urandom); df_off = $urandom; df_gate = $urandom % 2; df_ncs = $urandom % 2;
    flt_vec = 8'(10 + $urandom % 8); flt_code = $urandom;
  endtask

  function automatic int rpos();
    return ($urandom % 10 < 3) ? int'($urandom % 13) : 99;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, all requirements unchecked, actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rand_env();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!req_valid && !done && !rst_req, "R1", "reset state",
        {33'b0, req_valid, done, rst_req}, 36'd0);

    // R3 R6 R8: protected mode, ring 3 to ring 0, interrupt gate, error code, 32-bit
    rand_env(); pe = 1; cpl = 3; cs32 = 1; pri_sel[1:0] = 0; pri_gate = 1; pri_ncs = 1;
    deliver(1, 8'd13, 1, 32'h0000_0abc, 99, 99, 99);
    // R5 R8: real mode with 32-bit code, no error push, 16-bit pointer
    rand_env(); pe = 0; cs32 = 1; pri_gate = 0; pri_ncs = 0; pri_off = 32'hdead_beef;
    deliver(0, 8'd32, 1, 32'h1234, 99, 99, 99);
    // R8: same ring, 16-bit new segment error push
    rand_env(); pe = 1; cpl = 0; pri_ncs = 0;
    deliver(1, 8'd14, 1, 32'hffff_0007, 99, 99, 99);

    // R12: ack and fault while idle do nothing
    ack = 1; flt = 1;
    @(negedge clk);
    ack = 0; flt = 0;
    chk(!req_valid && !done && !rst_req, "R12", "idle ack ignored",
        {33'b0, req_valid, done, rst_req}, 36'd0);
    @(negedge clk);
    chk(!req_valid && !rst_req, "R12", "idle still", {34'b0, req_valid, rst_req}, 36'd0);
    // R12 R9: counter untouched, so one fault in an exception escalates to double fault only
    rand_env(); pe = 1;
    deliver(1, 8'd6, 0, 0, 2, 99, 99);
    // R9 R10: two faults after a completed exception reach reset
    rand_env();
    deliver(1, 8'd0, 0, 0, 0, 4, 99);
    // R9: interrupt with three faults
    rand_env();
    deliver(0, 8'd40, 0, 0, 3, 1, 0);
    // R9: interrupt with two faults completes through double fault
    rand_env(); pe = 1;
    deliver(0, 8'd41, 0, 0, 5, 2, 99);

    for (int i = 0; i < 120; i++) begin
      rand_env();
      deliver($urandom % 2, 8'($urandom % 7), $urandom % 2, $urandom, rpos(), rpos(), rpos());
      if ($urandom % 4 == 0) begin
        ack = 1; flt = $urandom % 2;
        @(negedge clk);
        ack = 0; flt = 0;
        chk(!req_valid && !done && !rst_req, "R12", "random idle ack",
            {33'b0, req_valid, done, rst_req}, 36'd0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule